// File: doc/BRIEF.md
# Context-Checked Paging Translator for an AHB-Lite Memory Path

This block sits between an AHB-Lite interconnect and a memory controller. It has three ports. The first is a memory-side AHB-Lite slave that receives CPU transfers. The second is an AHB-Lite master that issues transfers to the memory controller. The third is a small AHB-Lite configuration slave. The configuration slave lets software load the lookup table, set the context of the running program, inspect the last fault and acknowledge it.

Bit 26 of a memory-side address selects the path. When the bit is low, the address is physical and goes downstream unchanged. When the bit is high, the address is virtual, so the window 0x04000000 to 0x07FFFFFF is virtual. A virtual address is looked up in a fully associative table of 4 KB pages. Each table entry carries its own owner context and its own read and write permissions. A matching entry whose owner equals the current context and whose permission allows the access replaces the page number and forwards the transfer. Any other virtual access gets an AHB error response, is never forwarded, and raises a page-fault interrupt.

Top module: `ctx_mmu`

## Requirements
- R1: A memory-side transfer with address bit 26 low is issued downstream with the same address, direction and size. The block adds exactly one wait state beyond those of the memory controller.
- R2: A virtual transfer that hits and is permitted is issued downstream at address {entry physical page, address[11:0]}, with the same direction and size. Write data is passed through during the data phase. A downstream address phase is held stable while the downstream HREADY is low.
- R3: An entry matches only when its valid bit is set, its virtual page equals address[25:12], and its owner context equals the context register. An entry owned by another context is treated as a miss.
- R4: A virtual read needs the entry's read bit, and a virtual write needs the entry's write bit.
- R5: A virtual transfer that misses or lacks permission receives a two-cycle ERROR response: HRESP high with HREADYOUT low, then HRESP high with HREADYOUT high. No downstream transfer is issued for it.
- R6: A fault raises `pf_irq` in the cycle the ERROR response begins. The interrupt stays high until software writes 1 to bit 0 of the status register at configuration offset 0x004.
- R7: The status register has these bits: bit 0 = fault pending, bit 1 = permission fault (0 = no matching entry), bit 2 = faulting access was a write. The register at offset 0x008 holds the faulting address. Both registers keep the first fault until it is cleared, and later faults do not overwrite them.
- R8: Downstream wait states stall the memory-side transfer. HRDATA and HRESP are returned from downstream.
- R9: The context register at configuration offset 0x000 holds bits [3:0], resets to 0, and reads back what was written.
- R10: Table entry i is written at offset 0x100+8*i with the fields valid[31], owner context[23:20], write[17], read[16] and virtual page[13:0]. The physical page[19:0] is written at offset 0x104+8*i. Rewriting an entry changes the outcome of the next access.
- R11: After reset, the memory-side slave is ready with an OKAY response, the downstream master is idle, and `pf_irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| c_hsel | input | 1 | Configuration slave select |
| c_haddr | input | 12 | Configuration address |
| c_htrans | input | 2 | Configuration transfer type |
| c_hwrite | input | 1 | Configuration write |
| c_hwdata | input | 32 | Configuration write data |
| c_hready | input | 1 | Configuration bus ready |
| c_hreadyout | output | 1 | Configuration slave ready (always high) |
| c_hresp | output | 1 | Configuration response (always OKAY) |
| c_hrdata | output | 32 | Configuration read data |
| s_hsel | input | 1 | Memory-side slave select |
| s_haddr | input | 32 | Memory-side address |
| s_htrans | input | 2 | Memory-side transfer type |
| s_hwrite | input | 1 | Memory-side write |
| s_hsize | input | 3 | Memory-side transfer size |
| s_hwdata | input | 32 | Memory-side write data |
| s_hready | input | 1 | Memory-side bus ready |
| s_hreadyout | output | 1 | Memory-side slave ready |
| s_hresp | output | 1 | Memory-side response |
| s_hrdata | output | 32 | Memory-side read data |
| d_haddr | output | 32 | Downstream address |
| d_htrans | output | 2 | Downstream transfer type |
| d_hwrite | output | 1 | Downstream write |
| d_hsize | output | 3 | Downstream size |
| d_hwdata | output | 32 | Downstream write data |
| d_hready | input | 1 | Downstream ready |
| d_hresp | input | 1 | Downstream response |
| d_hrdata | input | 32 | Downstream read data |
| pf_irq | output | 1 | Page-fault interrupt, level |

## Verification
A table entry stored with a wrong page, owner or permission bit appears as a wrong downstream address. It can also appear as an ERROR where an OKAY was due, or the reverse. Either shows at the memory-side port in the data phase of the very next access to that page. A sequencer stuck in the wrong state shows at once: HREADYOUT stays low, an ERROR has a broken two-cycle shape, or a downstream transfer appears for a faulting access. Corrupted fault bookkeeping shows when the status and address registers are read after a fault, or when the interrupt fails to drop after the acknowledge write.

// File: rtl/ctx_mmu_pkg.sv
package ctx_mmu_pkg;
  // configuration port geometry
  localparam int CFG_AW = 12;
  localparam int CFG_DW = 32;

  // register offsets
  localparam logic [CFG_AW-1:0] OFS_CTX   = 12'h000;
  localparam logic [CFG_AW-1:0] OFS_STAT  = 12'h004;
  localparam logic [CFG_AW-1:0] OFS_FADDR = 12'h008;
  localparam logic [3:0]        TBL_PAGE  = 4'h1;

  // entry tag word field positions
  localparam int FLD_R   = 16;
  localparam int FLD_W   = 17;
  localparam int FLD_CTX = 20;
  localparam int FLD_V   = 31;

  localparam logic [1:0] HT_IDLE   = 2'b00;
  localparam logic [1:0] HT_NONSEQ = 2'b10;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_DATA,
    ST_ERR1,
    ST_ERR2
  } xl_state_t;
endpackage

// File: rtl/ctx_mmu_tlb.sv
module ctx_mmu_tlb #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 14,
  parameter int PPN_W   = 20,
  parameter int CTX_W   = 4,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_tag_en,
  input  logic             wr_ppn_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_valid,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [CTX_W-1:0] wr_ctx,
  input  logic             wr_r,
  input  logic             wr_w,
  input  logic [PPN_W-1:0] wr_ppn,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic [CTX_W-1:0] lk_ctx,
  input  logic             lk_write,
  output logic             lk_hit,
  output logic             lk_allow,
  output logic [PPN_W-1:0] lk_ppn
);
  logic [ENTRIES-1:0] v_q, r_q, w_q, match;
  logic [VPN_W-1:0]   vpn_q [ENTRIES];
  logic [CTX_W-1:0]   ctx_q [ENTRIES];
  logic [PPN_W-1:0]   ppn_q [ENTRIES];
  logic [IDX_W-1:0]   sel;

  // only the valid bits need a reset; payload fields are plain storage
  always_ff @(posedge clk) begin
    if (rst) begin
      v_q <= '0;
      r_q <= '0;
      w_q <= '0;
    end else if (wr_tag_en) begin
      v_q[wr_idx] <= wr_valid;
      r_q[wr_idx] <= wr_r;
      w_q[wr_idx] <= wr_w;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_tag_en) begin
      vpn_q[wr_idx] <= wr_vpn;
      ctx_q[wr_idx] <= wr_ctx;
    end
    if (wr_ppn_en) ppn_q[wr_idx] <= wr_ppn;
  end

  // one comparator per entry
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = v_q[g] && (vpn_q[g] == lk_vpn) && (ctx_q[g] == lk_ctx);
  end

  // lowest matching index wins
  always_comb begin
    sel = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) sel = IDX_W'(i);
    end
  end

  assign lk_hit   = |match;
  assign lk_ppn   = ppn_q[sel];
  assign lk_allow = lk_write ? w_q[sel] : r_q[sel];
endmodule

// File: rtl/ctx_mmu_cfg.sv
module ctx_mmu_cfg
  import ctx_mmu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CTX_W  = 4,
  parameter int VPN_W  = 14,
  parameter int PPN_W  = 20,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              c_hsel,
  input  logic [CFG_AW-1:0] c_haddr,
  input  logic [1:0]        c_htrans,
  input  logic              c_hwrite,
  input  logic [CFG_DW-1:0] c_hwdata,
  input  logic              c_hready,
  output logic              c_hreadyout,
  output logic              c_hresp,
  output logic [CFG_DW-1:0] c_hrdata,
  output logic [CTX_W-1:0]  ctx_o,
  output logic              tbl_tag_we,
  output logic              tbl_ppn_we,
  output logic [IDX_W-1:0]  tbl_idx,
  output logic              tbl_valid,
  output logic [VPN_W-1:0]  tbl_vpn,
  output logic [CTX_W-1:0]  tbl_ctx,
  output logic              tbl_r,
  output logic              tbl_w,
  output logic [PPN_W-1:0]  tbl_ppn,
  input  logic              flt_set,
  input  logic [ADDR_W-1:0] flt_addr_i,
  input  logic              flt_perm_i,
  input  logic              flt_wr_i,
  output logic              irq
);
  logic              ap_valid, ap_write;
  logic [CFG_AW-1:0] ap_addr;
  logic [CFG_DW-1:0] rdata_q, rd_mux;
  logic [CTX_W-1:0]  ctx_q;
  logic              pend_q, perm_q, fwr_q;
  logic [ADDR_W-1:0] faddr_q;
  logic              acc, wr_now, clr_req, in_tbl;
  logic              unused_cfg;

  assign acc     = c_hsel && c_htrans[1] && c_hready;
  assign wr_now  = ap_valid && ap_write;
  assign in_tbl  = (ap_addr[CFG_AW-1:8] == TBL_PAGE);
  assign clr_req = wr_now && (ap_addr == OFS_STAT) && c_hwdata[0];

  always_comb begin
    case (c_haddr)
      OFS_CTX:   rd_mux = {{(CFG_DW-CTX_W){1'b0}}, ctx_q};
      OFS_STAT:  rd_mux = {{(CFG_DW-3){1'b0}}, fwr_q, perm_q, pend_q};
      OFS_FADDR: rd_mux = CFG_DW'(faddr_q);
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ap_valid <= 1'b0;
      ap_write <= 1'b0;
      ap_addr  <= '0;
      rdata_q  <= '0;
      ctx_q    <= '0;
      pend_q   <= 1'b0;
      perm_q   <= 1'b0;
      fwr_q    <= 1'b0;
      faddr_q  <= '0;
    end else begin
      ap_valid <= acc;
      ap_write <= c_hwrite;
      ap_addr  <= c_haddr;
      if (acc && !c_hwrite) rdata_q <= rd_mux;
      if (wr_now && ap_addr == OFS_CTX) ctx_q <= c_hwdata[CTX_W-1:0];
      // a new fault has priority over an acknowledge in the same cycle
      if (flt_set) begin
        if (!pend_q) begin
          faddr_q <= flt_addr_i;
          perm_q  <= flt_perm_i;
          fwr_q   <= flt_wr_i;
        end
        pend_q <= 1'b1;
      end else if (clr_req) begin
        pend_q <= 1'b0;
      end
    end
  end

  assign tbl_tag_we  = wr_now && in_tbl && !ap_addr[2];
  assign tbl_ppn_we  = wr_now && in_tbl && ap_addr[2];
  assign tbl_idx     = ap_addr[IDX_W+2:3];
  assign tbl_valid   = c_hwdata[FLD_V];
  assign tbl_ctx     = c_hwdata[FLD_CTX +: CTX_W];
  assign tbl_r       = c_hwdata[FLD_R];
  assign tbl_w       = c_hwdata[FLD_W];
  assign tbl_vpn     = c_hwdata[VPN_W-1:0];
  assign tbl_ppn     = c_hwdata[PPN_W-1:0];

  assign c_hreadyout = 1'b1;
  assign c_hresp     = 1'b0;
  assign c_hrdata    = rdata_q;
  assign ctx_o       = ctx_q;
  assign irq         = pend_q;

  assign unused_cfg  = ^{c_hwdata, ap_addr, c_htrans[0]};
endmodule

// File: rtl/ctx_mmu_xlate.sv
module ctx_mmu_xlate
  import ctx_mmu_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int PAGE_W   = 12,
  parameter int VIRT_BIT = 26,
  localparam int PPN_W   = ADDR_W - PAGE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s_hsel,
  input  logic [ADDR_W-1:0] s_haddr,
  input  logic [1:0]        s_htrans,
  input  logic              s_hwrite,
  input  logic [2:0]        s_hsize,
  input  logic [DATA_W-1:0] s_hwdata,
  input  logic              s_hready,
  output logic              s_hreadyout,
  output logic              s_hresp,
  output logic [DATA_W-1:0] s_hrdata,
  output logic [ADDR_W-1:0] d_haddr,
  output logic [1:0]        d_htrans,
  output logic              d_hwrite,
  output logic [2:0]        d_hsize,
  output logic [DATA_W-1:0] d_hwdata,
  input  logic              d_hready,
  input  logic              d_hresp,
  input  logic [DATA_W-1:0] d_hrdata,
  input  logic              lk_hit,
  input  logic              lk_allow,
  input  logic [PPN_W-1:0]  lk_ppn,
  output logic              flt_set,
  output logic [ADDR_W-1:0] flt_addr,
  output logic              flt_perm,
  output logic              flt_wr
);
  xl_state_t st;
  logic      acc, open, take, is_virt, fault;
  logic      unused_xl;

  assign acc     = s_hsel && s_htrans[1] && s_hready;
  // states in which the previous data phase completes this cycle
  assign open    = (st == ST_IDLE) || (st == ST_ERR2) || (st == ST_DATA && d_hready);
  assign take    = acc && open;
  assign is_virt = s_haddr[VIRT_BIT];
  assign fault   = is_virt && !(lk_hit && lk_allow);

  assign flt_set  = take && fault;
  assign flt_addr = s_haddr;
  assign flt_perm = lk_hit;
  assign flt_wr   = s_hwrite;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      d_haddr  <= '0;
      d_hwrite <= 1'b0;
      d_hsize  <= '0;
    end else if (take) begin
      if (fault) begin
        st <= ST_ERR1;
      end else begin
        st       <= ST_ISSUE;
        d_haddr  <= is_virt ? {lk_ppn, s_haddr[PAGE_W-1:0]} : s_haddr;
        d_hwrite <= s_hwrite;
        d_hsize  <= s_hsize;
      end
    end else begin
      case (st)
        ST_ISSUE: if (d_hready) st <= ST_DATA;
        ST_ERR1:  st <= ST_ERR2;
        ST_DATA:  if (d_hready) st <= ST_IDLE;
        default:  st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    case (st)
      ST_ISSUE: begin s_hreadyout = 1'b0;     s_hresp = 1'b0;    end
      ST_DATA:  begin s_hreadyout = d_hready; s_hresp = d_hresp; end
      ST_ERR1:  begin s_hreadyout = 1'b0;     s_hresp = 1'b1;    end
      ST_ERR2:  begin s_hreadyout = 1'b1;     s_hresp = 1'b1;    end
      default:  begin s_hreadyout = 1'b1;     s_hresp = 1'b0;    end
    endcase
  end

  assign d_htrans = (st == ST_ISSUE) ? HT_NONSEQ : HT_IDLE;
  assign d_hwdata = s_hwdata;
  assign s_hrdata = d_hrdata;

  assign unused_xl = s_htrans[0];
endmodule

// File: rtl/ctx_mmu.sv
module ctx_mmu
  import ctx_mmu_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int ENTRIES  = 16,
  parameter int CTX_W    = 4,
  parameter int PAGE_W   = 12,
  parameter int VIRT_BIT = 26
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              c_hsel,
  input  logic [11:0]       c_haddr,
  input  logic [1:0]        c_htrans,
  input  logic              c_hwrite,
  input  logic [31:0]       c_hwdata,
  input  logic              c_hready,
  output logic              c_hreadyout,
  output logic              c_hresp,
  output logic [31:0]       c_hrdata,
  input  logic              s_hsel,
  input  logic [ADDR_W-1:0] s_haddr,
  input  logic [1:0]        s_htrans,
  input  logic              s_hwrite,
  input  logic [2:0]        s_hsize,
  input  logic [DATA_W-1:0] s_hwdata,
  input  logic              s_hready,
  output logic              s_hreadyout,
  output logic              s_hresp,
  output logic [DATA_W-1:0] s_hrdata,
  output logic [ADDR_W-1:0] d_haddr,
  output logic [1:0]        d_htrans,
  output logic              d_hwrite,
  output logic [2:0]        d_hsize,
  output logic [DATA_W-1:0] d_hwdata,
  input  logic              d_hready,
  input  logic              d_hresp,
  input  logic [DATA_W-1:0] d_hrdata,
  output logic              pf_irq
);
  localparam int VPN_W = VIRT_BIT - PAGE_W;
  localparam int PPN_W = ADDR_W - PAGE_W;
  localparam int IDX_W = $clog2(ENTRIES);

  logic [CTX_W-1:0]  ctx;
  logic              tag_we, ppn_we, t_valid, t_r, t_w;
  logic [IDX_W-1:0]  t_idx;
  logic [VPN_W-1:0]  t_vpn;
  logic [CTX_W-1:0]  t_ctx;
  logic [PPN_W-1:0]  t_ppn;
  logic              hit, allow;
  logic [PPN_W-1:0]  ppn;
  logic              f_set, f_perm, f_wr;
  logic [ADDR_W-1:0] f_addr;

  ctx_mmu_cfg #(
    .ADDR_W(ADDR_W), .CTX_W(CTX_W), .VPN_W(VPN_W), .PPN_W(PPN_W), .IDX_W(IDX_W)
  ) u_cfg (
    .clk(clk), .rst(rst),
    .c_hsel(c_hsel), .c_haddr(c_haddr), .c_htrans(c_htrans), .c_hwrite(c_hwrite),
    .c_hwdata(c_hwdata), .c_hready(c_hready), .c_hreadyout(c_hreadyout),
    .c_hresp(c_hresp), .c_hrdata(c_hrdata),
    .ctx_o(ctx), .tbl_tag_we(tag_we), .tbl_ppn_we(ppn_we), .tbl_idx(t_idx),
    .tbl_valid(t_valid), .tbl_vpn(t_vpn), .tbl_ctx(t_ctx), .tbl_r(t_r),
    .tbl_w(t_w), .tbl_ppn(t_ppn),
    .flt_set(f_set), .flt_addr_i(f_addr), .flt_perm_i(f_perm), .flt_wr_i(f_wr),
    .irq(pf_irq)
  );

  ctx_mmu_tlb #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .CTX_W(CTX_W)
  ) u_tlb (
    .clk(clk), .rst(rst),
    .wr_tag_en(tag_we), .wr_ppn_en(ppn_we), .wr_idx(t_idx), .wr_valid(t_valid),
    .wr_vpn(t_vpn), .wr_ctx(t_ctx), .wr_r(t_r), .wr_w(t_w), .wr_ppn(t_ppn),
    .lk_vpn(s_haddr[VIRT_BIT-1:PAGE_W]), .lk_ctx(ctx), .lk_write(s_hwrite),
    .lk_hit(hit), .lk_allow(allow), .lk_ppn(ppn)
  );

  ctx_mmu_xlate #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W), .VIRT_BIT(VIRT_BIT)
  ) u_xlate (
    .clk(clk), .rst(rst),
    .s_hsel(s_hsel), .s_haddr(s_haddr), .s_htrans(s_htrans), .s_hwrite(s_hwrite),
    .s_hsize(s_hsize), .s_hwdata(s_hwdata), .s_hready(s_hready),
    .s_hreadyout(s_hreadyout), .s_hresp(s_hresp), .s_hrdata(s_hrdata),
    .d_haddr(d_haddr), .d_htrans(d_htrans), .d_hwrite(d_hwrite), .d_hsize(d_hsize),
    .d_hwdata(d_hwdata), .d_hready(d_hready), .d_hresp(d_hresp), .d_hrdata(d_hrdata),
    .lk_hit(hit), .lk_allow(allow), .lk_ppn(ppn),
    .flt_set(f_set), .flt_addr(f_addr), .flt_perm(f_perm), .flt_wr(f_wr)
  );
endmodule

// File: rtl/ctx_mmu_chk.sv
module ctx_mmu_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              s_hreadyout,
  input logic              s_hresp,
  input logic [ADDR_W-1:0] d_haddr,
  input logic [1:0]        d_htrans,
  input logic              d_hready,
  input logic              pf_irq
);
  // R5
  err_shape_chk: assert property (@(posedge clk) disable iff (rst)
    (s_hresp && !s_hreadyout) |=> (s_hresp && s_hreadyout));

  // R5
  err_no_fwd_chk: assert property (@(posedge clk) disable iff (rst)
    (s_hresp && !s_hreadyout) |-> (d_htrans == 2'b00));

  // R8
  dn_stall_chk: assert property (@(posedge clk) disable iff (rst)
    !d_hready |-> !s_hreadyout);

  // R2
  dn_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (d_htrans[1] && !d_hready) |=> (d_htrans[1] && $stable(d_haddr)));

  // R6
  irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pf_irq) |-> (s_hresp && !s_hreadyout));
endmodule

bind ctx_mmu ctx_mmu_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .s_hreadyout(s_hreadyout), .s_hresp(s_hresp),
  .d_haddr(d_haddr), .d_htrans(d_htrans), .d_hready(d_hready), .pf_irq(pf_irq)
);

// File: tb/ctx_mmu_bench.sv
module ctx_mmu_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        c_hsel = 1'b0, c_hwrite = 1'b0;
  logic [11:0] c_haddr = '0;
  logic [1:0]  c_htrans = '0;
  logic [31:0] c_hwdata = '0;
  logic        c_hreadyout, c_hresp;
  logic [31:0] c_hrdata;
  logic        s_hsel = 1'b0, s_hwrite = 1'b0;
  logic [31:0] s_haddr = '0, s_hwdata = '0;
  logic [1:0]  s_htrans = '0;
  logic [2:0]  s_hsize = 3'd2;
  logic        s_hreadyout, s_hresp;
  logic [31:0] s_hrdata;
  logic [31:0] d_haddr, d_hwdata, d_hrdata;
  logic [1:0]  d_htrans;
  logic        d_hwrite, d_hready;
  logic [2:0]  d_hsize;
  logic        pf_irq;

  // 4 time units per period: 250 MHz with 1 ns units
  always #2 clk = ~clk;

  ctx_mmu u_ctx_mmu (
    .clk(clk), .rst(rst),
    .c_hsel(c_hsel), .c_haddr(c_haddr), .c_htrans(c_htrans), .c_hwrite(c_hwrite),
    .c_hwdata(c_hwdata), .c_hready(c_hreadyout), .c_hreadyout(c_hreadyout),
    .c_hresp(c_hresp), .c_hrdata(c_hrdata),
    .s_hsel(s_hsel), .s_haddr(s_haddr), .s_htrans(s_htrans), .s_hwrite(s_hwrite),
    .s_hsize(s_hsize), .s_hwdata(s_hwdata), .s_hready(s_hreadyout),
    .s_hreadyout(s_hreadyout), .s_hresp(s_hresp), .s_hrdata(s_hrdata),
    .d_haddr(d_haddr), .d_htrans(d_htrans), .d_hwrite(d_hwrite), .d_hsize(d_hsize),
    .d_hwdata(d_hwdata), .d_hready(d_hready), .d_hresp(1'b0), .d_hrdata(d_hrdata),
    .pf_irq(pf_irq)
  );

  // downstream memory controller model with programmable wait states
  logic        dp_act = 1'b0, dp_wr = 1'b0;
  logic [31:0] dp_addr = '0, last_wa = '0, last_wd = '0;
  logic [2:0]  dp_sz = '0, last_sz = '0;
  int          waits_left = 0, wait_cfg = 0, dn_cnt = 0;

  assign d_hready = !dp_act || (waits_left == 0);
  assign d_hrdata = dp_act ? (dp_addr ^ 32'h5A5A_0000) : 32'h0;

  always @(posedge clk) begin
    if (d_hready) begin
      if (dp_act) begin
        dn_cnt <= dn_cnt + 1;
        if (dp_wr) begin
          last_wa <= dp_addr;
          last_wd <= d_hwdata;
          last_sz <= dp_sz;
        end
      end
      dp_act     <= d_htrans[1];
      dp_addr    <= d_haddr;
      dp_wr      <= d_hwrite;
      dp_sz      <= d_hsize;
      waits_left <= wait_cfg;
    end else begin
      waits_left <= waits_left - 1;
    end
  end

  int checks = 0, fails = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    c_hsel = 1'b1; c_haddr = a; c_htrans = 2'b10; c_hwrite = 1'b1;
    @(posedge clk);
    @(negedge clk);
    c_hsel = 1'b0; c_htrans = 2'b00; c_hwdata = d;
    @(posedge clk);
  endtask

  task automatic cfg_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    c_hsel = 1'b1; c_haddr = a; c_htrans = 2'b10; c_hwrite = 1'b0;
    @(posedge clk);
    @(negedge clk);
    c_hsel = 1'b0; c_htrans = 2'b00;
    d = c_hrdata;
  endtask

  task automatic set_entry(input int idx, input logic v, input logic [13:0] vpn,
                           input logic [3:0] cx, input logic r, input logic w,
                           input logic [19:0] ppn);
    cfg_wr(12'h100 + 12'(idx * 8),
           {v, 7'b0, cx, 2'b0, w, r, 2'b0, vpn});
    cfg_wr(12'h104 + 12'(idx * 8), {12'b0, ppn});
  endtask

  task automatic mem_xfer(input logic [31:0] a, input logic w, input logic [2:0] sz,
                          input logic [31:0] wd, output logic [31:0] rd,
                          output logic rsp, output int stalls, output logic saw_e1);
    @(negedge clk);
    s_hsel = 1'b1; s_haddr = a; s_htrans = 2'b10; s_hwrite = w; s_hsize = sz;
    @(posedge clk);
    @(negedge clk);
    s_hsel = 1'b0; s_htrans = 2'b00; s_hwdata = wd;
    stalls = 0; saw_e1 = 1'b0;
    while (!s_hreadyout) begin
      stalls++;
      if (s_hresp) saw_e1 = 1'b1;
      @(negedge clk);
    end
    rd = s_hrdata;
    rsp = s_hresp;
    @(posedge clk);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  // stimulus / expected vectors, run with context 3
  localparam int NV = 10;
  localparam logic [31:0] VA [NV] = '{32'h0400_5010, 32'h0400_5FFC, 32'h0400_6020,
    32'h0400_6020, 32'h0400_7000, 32'h0400_8000, 32'h0400_9000, 32'h0000_1234,
    32'h03FF_FFF0, 32'h0800_5010};
  localparam bit VW [NV] = '{0, 1, 0, 1, 0, 0, 0, 0, 1, 0};
  localparam bit VE [NV] = '{0, 0, 0, 1, 1, 1, 1, 0, 0, 0};
  localparam bit VP [NV] = '{0, 0, 0, 1, 0, 0, 0, 0, 0, 0};
  localparam logic [2:0] VS [NV] = '{3'd2, 3'd0, 3'd2, 3'd2, 3'd2, 3'd2, 3'd2,
    3'd2, 3'd1, 3'd2};
  localparam logic [31:0] VD [NV] = '{32'h1234_5010, 32'h1234_5FFC, 32'h00AB_C020,
    32'h0, 32'h0, 32'h0, 32'h0, 32'h0000_1234, 32'h03FF_FFF0, 32'h0800_5010};

  logic [31:0] rd, rv;
  logic        rsp, se;
  int          stl, dn0;

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk("R11 hreadyout", 32'(s_hreadyout), 32'd1);
    chk("R11 hresp", 32'(s_hresp), 32'd0);
    chk("R11 d_htrans", 32'(d_htrans), 32'd0);
    chk("R11 irq", 32'(pf_irq), 32'd0);
    cfg_rd(12'h000, rv);
    chk("R9 ctx reset", rv, 32'd0);
    cfg_wr(12'h000, 32'hFFFF_FFF3);
    cfg_rd(12'h000, rv);
    chk("R9 ctx readback", rv, 32'd3);

    // R10 table load
    set_entry(0, 1'b1, 14'h005, 4'd3, 1'b1, 1'b1, 20'h12345);
    set_entry(1, 1'b1, 14'h006, 4'd3, 1'b1, 1'b0, 20'h00ABC);
    set_entry(2, 1'b1, 14'h007, 4'd5, 1'b1, 1'b1, 20'h0F00F);
    set_entry(3, 1'b0, 14'h008, 4'd3, 1'b1, 1'b1, 20'h00777);

    for (int i = 0; i < NV; i++) begin
      dn0 = dn_cnt;
      mem_xfer(VA[i], VW[i], VS[i], 32'hC0DE_0000 + 32'(i), rd, rsp, stl, se);
      @(negedge clk);
      if (VE[i]) begin
        chk("R5 error resp", 32'(rsp), 32'd1);
        chk("R5 first error cycle", 32'(se), 32'd1);
        chk("R5 not forwarded", 32'(dn_cnt), 32'(dn0));
        chk("R6 irq raised", 32'(pf_irq), 32'd1);
        cfg_rd(12'h004, rv);
        chk(VP[i] ? "R4 status perm" : "R3 status miss", rv,
            {29'b0, VW[i], VP[i], 1'b1});
        cfg_rd(12'h008, rv);
        chk("R7 fault addr", rv, VA[i]);
        cfg_wr(12'h004, 32'd1);
        @(negedge clk);
        chk("R6 irq cleared", 32'(pf_irq), 32'd0);
      end else begin
        chk(VA[i][26] ? "R2 okay resp" : "R1 okay resp", 32'(rsp), 32'd0);
        chk("R1 one wait state", 32'(stl), 32'd1);
        if (VW[i]) begin
          chk(VA[i][26] ? "R2 write addr" : "R1 write addr", last_wa, VD[i]);
          chk("R2 write data", last_wd, 32'hC0DE_0000 + 32'(i));
          chk("R2 write size", 32'(last_sz), 32'(VS[i]));
        end else begin
          chk(VA[i][26] ? "R2 read data" : "R1 read data", rd, VD[i] ^ 32'h5A5A_0000);
        end
      end
    end

    // R7 first fault is kept, R6 level holds
    mem_xfer(32'h0400_9000, 1'b0, 3'd2, 32'h0, rd, rsp, stl, se);
    mem_xfer(32'h0400_6020, 1'b1, 3'd2, 32'h0, rd, rsp, stl, se);
    repeat (5) @(negedge clk);
    chk("R6 irq held", 32'(pf_irq), 32'd1);
    cfg_rd(12'h008, rv);
    chk("R7 sticky addr", rv, 32'h0400_9000);
    cfg_rd(12'h004, rv);
    chk("R7 sticky status", rv, 32'd1);
    cfg_wr(12'h004, 32'd1);
    @(negedge clk);
    chk("R6 irq cleared again", 32'(pf_irq), 32'd0);

    // R3 context switch
    cfg_wr(12'h000, 32'd5);
    mem_xfer(32'h0400_7000, 1'b0, 3'd2, 32'h0, rd, rsp, stl, se);
    chk("R3 other ctx hit resp", 32'(rsp), 32'd0);
    chk("R3 other ctx data", rd, 32'h0F00_F000 ^ 32'h5A5A_0000);
    mem_xfer(32'h0400_5010, 1'b0, 3'd2, 32'h0, rd, rsp, stl, se);
    chk("R3 foreign entry faults", 32'(rsp), 32'd1);
    cfg_wr(12'h004, 32'd1);
    cfg_wr(12'h000, 32'd3);

    // R4 / R10 run-time permission change and invalidation
    set_entry(1, 1'b1, 14'h006, 4'd3, 1'b1, 1'b1, 20'h00ABC);
    mem_xfer(32'h0400_6020, 1'b1, 3'd2, 32'h0000_FEED, rd, rsp, stl, se);
    @(negedge clk);
    chk("R4 write granted", 32'(rsp), 32'd0);
    chk("R10 write addr", last_wa, 32'h00AB_C020);
    set_entry(0, 1'b0, 14'h005, 4'd3, 1'b1, 1'b1, 20'h12345);
    mem_xfer(32'h0400_5010, 1'b0, 3'd2, 32'h0, rd, rsp, stl, se);
    chk("R10 invalidated faults", 32'(rsp), 32'd1);
    cfg_wr(12'h004, 32'd1);

    // R8 downstream wait states
    wait_cfg = 2;
    mem_xfer(32'h0000_1234, 1'b0, 3'd2, 32'h0, rd, rsp, stl, se);
    chk("R8 stall count phys", 32'(stl), 32'd3);
    chk("R8 read data phys", rd, 32'h0000_1234 ^ 32'h5A5A_0000);
    mem_xfer(32'h0400_6020, 1'b0, 3'd2, 32'h0, rd, rsp, stl, se);
    chk("R8 stall count virt", 32'(stl), 32'd3);
    chk("R8 read data virt", rd, 32'h00AB_C020 ^ 32'h5A5A_0000);
    wait_cfg = 0;

    repeat (4) @(negedge clk);
    summary();
  end
endmodule